// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a register-programmed interval timer for a bus-attached peripheral slot. A prescaler divides the bus clock by a programmable divisor. Each prescaled tick advances a 28-bit up-counter. When the counter reaches a programmed limit it wraps to zero and latches a pending interrupt flag. In single-shot mode the counter then parks at zero. In looping mode it keeps going and flags every period.

Software uses a single-cycle, word-addressed port that holds four registers:

| Byte offset | Register | Contents |
|---|---|---|
| 0x0 | Limit | Limit value |
| 0x4 | Count | Live count, read-only |
| 0x8 | Control | Run enable (bit 28), mode (bit 24, 0 = single-shot, 1 = looping), divisor (bits 15:0) |
| 0xC | Interrupt | Interrupt enable (bit 20), pending flag (bit 16, write-one-to-clear) |

The level interrupt output is the pending flag gated by the interrupt enable. A run starts only from the stopped state: a 0-to-1 change of the run enable bit clears the counter and the prescaler phase.

Top module: `pit_top`

## Requirements
- R1: After reset all four registers read zero and `irq_o` is low.
- R2: The limit register stores the low 28 bits of a write and reads them back, with bits 31:28 as zero. Writes to the count register (offset 0x4) change nothing.
- R3: On a prescaled tick where count equals limit, the count becomes 0 and the pending flag (interrupt register bit 16) is set. On any other counted tick, the count increases by one.
- R4: With divisor N in 2..65535, a counted tick occurs every N bus clocks. The first one lands N clocks after the enabling write edge, so the count after k clocks is derived from floor(k/N) ticks.
- R5: A divisor of 0 or 1 stops the timer clock, and the count holds even with the run enable at 1.
- R6: In single-shot mode (mode bit 0), the counter stays at 0 after its wrap. Writing the run enable as 1 while it is already 1 does not restart it. Only a 0-to-1 transition of the run enable restarts it.
- R7: In looping mode (mode bit 1), counting continues after each wrap, and the count after t ticks is t mod (limit+1).
- R8: Writing 1 to bit 16 of the interrupt register clears the pending flag. Writing 0 there leaves it unchanged.
- R9: `irq_o` is high exactly when the pending flag and the interrupt enable bit (interrupt register bit 20) are both 1.
- R10: A 0-to-1 write of the run enable clears the count at once. Clearing the run enable freezes the count. Rewriting the control register with unchanged contents while running neither clears the count nor disturbs the tick phase.
- R11: Writing a different divisor while running restarts the prescaler phase, so the next tick comes a full new divisor after that write edge.
- R12: Unused register bits read zero. For example, writing all ones to control reads back 0x1100FFFF, and writing all ones to the interrupt register reads back 0x00100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the accessed register; bits 3:2 select the word |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Register writes take effect at the clock edge that samples the strobe. Reads are combinational, so the bench samples `bus_rdata` and `irq_o` 1 ns after an edge, with no extra cycle of latency.

Counting results are due a fixed number of edges after the enabling write. Once k edges have passed that write, the count reflects floor(k/N) ticks. The bench waits exactly k edges before sampling and computes count, pending flag and interrupt from k, N, the limit and the mode.

Divisor-change checks are placed one edge before and at the edge where the restarted phase must deliver its first tick. A stale phase would show up as an early increment.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
   localparam int unsigned BUS_W = 32;

   typedef enum logic [1:0] {
      SEL_LIMIT = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_IRQ   = 2'd3
   } pit_sel_e;

   typedef enum logic {
      RUN_ONCE = 1'b0,
      RUN_LOOP = 1'b1
   } pit_mode_e;
endpackage

// File: rtl/pit_prescaler.sv
`timescale 1ns/1ps
module pit_prescaler #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   input  logic             restart,
   output logic             tick
);
   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

   logic [DIV_W-1:0] phase_q;
   logic             active;
   logic             at_end;

   assign active = run && (divisor >= DIV_MIN);
   assign at_end = (phase_q == divisor - DIV_W'(1));
   assign tick   = active && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!active || restart || at_end) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + DIV_W'(1);
      end
   end

   // R4: with a divisor of at least two, ticks never come back to back
   assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter #(
   parameter int unsigned CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             run,
   input  logic             loop_mode,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic             parked_q;
   logic             step;

   assign step  = tick && run && !parked_q && !start;
   assign wrap  = step && (cnt_q == limit);
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         parked_q <= 1'b0;
      end else if (start) begin
         cnt_q    <= '0;
         parked_q <= 1'b0;
      end else if (wrap) begin
         cnt_q    <= '0;
         parked_q <= !loop_mode;
      end else if (step) begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   // R3: a wrap leaves the counter at zero
   assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));

   // R6: after a single-shot wrap the count stays parked unless restarted
   assert_once_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !loop_mode) ##1 !start |=> (count == '0));

   // R10: a start clears the count on the next cycle
   assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (count == '0));
endmodule

// File: rtl/pit_top.sv
`timescale 1ns/1ps
module pit_top
   import pit_pkg::*;
#(
   parameter int unsigned CNT_W    = 28,
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned EN_BIT   = 28,
   parameter int unsigned MODE_BIT = 24,
   parameter int unsigned IE_BIT   = 20,
   parameter int unsigned PEND_BIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       bus_addr,
   input  logic             bus_we,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq_o
);
   localparam int unsigned PAD_W = BUS_W - CNT_W;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("pit_top: CNT_W out of range");
   end
   if (DIV_W < 2 || DIV_W > MODE_BIT || DIV_W > PEND_BIT) begin : g_bad_div
      $error("pit_top: divisor field overlaps flag bits");
   end
   if (EN_BIT >= BUS_W || EN_BIT == MODE_BIT || IE_BIT == PEND_BIT) begin : g_bad_bits
      $error("pit_top: flag bit positions invalid");
   end

   pit_sel_e         sel;
   logic             wr_limit, wr_ctrl, wr_irq;
   logic [CNT_W-1:0] limit_q;
   logic             en_q, ie_q, pend_q;
   pit_mode_e        mode_q;
   logic [DIV_W-1:0] div_q;
   logic             start, div_change, tick, wrap;
   logic [CNT_W-1:0] count;
   logic [BUS_W-1:0] limit_rd, count_rd;

   assign sel        = pit_sel_e'(bus_addr[3:2]);
   assign wr_limit   = bus_we && (sel == SEL_LIMIT);
   assign wr_ctrl    = bus_we && (sel == SEL_CTRL);
   assign wr_irq     = bus_we && (sel == SEL_IRQ);
   assign start      = wr_ctrl && !en_q && bus_wdata[EN_BIT];
   assign div_change = wr_ctrl && (bus_wdata[DIV_W-1:0] != div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '0;
         en_q    <= 1'b0;
         mode_q  <= RUN_ONCE;
         div_q   <= '0;
         ie_q    <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
         if (wr_ctrl) begin
            en_q   <= bus_wdata[EN_BIT];
            mode_q <= pit_mode_e'(bus_wdata[MODE_BIT]);
            div_q  <= bus_wdata[DIV_W-1:0];
         end
         if (wr_irq) ie_q <= bus_wdata[IE_BIT];
         if (wrap) pend_q <= 1'b1;
         else if (wr_irq && bus_wdata[PEND_BIT]) pend_q <= 1'b0;
      end
   end

   pit_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .divisor (div_q),
      .restart (div_change || start),
      .tick    (tick)
   );

   pit_counter #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start     (start),
      .run       (en_q),
      .loop_mode (mode_q == RUN_LOOP),
      .limit     (limit_q),
      .count     (count),
      .wrap      (wrap)
   );

   if (PAD_W > 0) begin : g_pad
      assign limit_rd = {{PAD_W{1'b0}}, limit_q};
      assign count_rd = {{PAD_W{1'b0}}, count};
   end else begin : g_full
      assign limit_rd = limit_q;
      assign count_rd = count;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_LIMIT: bus_rdata = limit_rd;
         SEL_COUNT: bus_rdata = count_rd;
         SEL_CTRL: begin
            bus_rdata[EN_BIT]      = en_q;
            bus_rdata[MODE_BIT]    = mode_q;
            bus_rdata[DIV_W-1:0]   = div_q;
         end
         SEL_IRQ: begin
            bus_rdata[IE_BIT]   = ie_q;
            bus_rdata[PEND_BIT] = pend_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign irq_o = pend_q && ie_q;

   // R5: with the timer clock off and no control write, the count holds
   assert_clock_off_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q < DIV_W'(2) && !wr_ctrl) |=> $stable(count));

   // R3: a wrap always leaves the pending flag set
   assert_wrap_sets_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> pend_q);

   // R8: a write-one clear without a concurrent wrap drops the flag
   assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_irq && bus_wdata[PEND_BIT] && !wrap) |=> !pend_q);
endmodule

// File: tb/pit_top_tb_top.sv
`timescale 1ns/1ps
module pit_top_tb_top;
   localparam logic [3:0] A_LIM = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_IRQ = 4'hC;
   localparam logic [31:0] EN = 32'h1000_0000, LOOP = 32'h0100_0000;
   localparam logic [31:0] IE = 32'h0010_0000, PEND = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pit_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_count(input int k, input int n, input int lim, input bit loop);
      int t = k / n;
      if (loop) return 32'(t % (lim + 1));
      return (t <= lim) ? 32'(t) : 32'd0;
   endfunction

   function automatic bit exp_pend(input int k, input int n, input int lim);
      return (k / n) >= (lim + 1);
   endfunction

   task automatic arm(input int lim, input int n, input bit loop, input bit ie);
      wr(A_CTL, 32'h0);
      wr(A_LIM, 32'(lim));
      wr(A_IRQ, PEND | (ie ? IE : 32'h0));
      wr(A_CTL, EN | (loop ? LOOP : 32'h0) | 32'(n));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, v2;
      void'($urandom(32'd20240117));
      wait_edges(3);
      rst_n = 1'b1;
      wait_edges(1);

      // R1 reset state
      rd(A_LIM, v); chk("R1 limit", v, 0);
      rd(A_CNT, v); chk("R1 count", v, 0);
      rd(A_CTL, v); chk("R1 ctrl", v, 0);
      rd(A_IRQ, v); chk("R1 irq reg", v, 0);
      chk("R1 irq_o", {31'b0, irq_o}, 0);

      // R2 limit masking, count read-only
      wr(A_LIM, 32'hFFFF_FFFF);
      rd(A_LIM, v); chk("R2 limit mask", v, 32'h0FFF_FFFF);
      rd(A_CNT, v2);
      wr(A_CNT, 32'h0000_0123);
      rd(A_CNT, v); chk("R2 count write ignored", v, v2);

      // R12 readback of unused bits
      wr(A_CTL, 32'hFFFF_FFFF);
      rd(A_CTL, v); chk("R12 ctrl readback", v, 32'h1100_FFFF);
      wr(A_CTL, 32'h0);
      wr(A_IRQ, 32'hFFFF_FFFF);
      rd(A_IRQ, v); chk("R12 irq readback", v, 32'h0010_0000);
      wr(A_IRQ, 32'h0);

      // R5 divisor 0 and 1 stop counting
      arm(3, 0, 1'b1, 1'b0);
      wait_edges(40);
      rd(A_CNT, v); chk("R5 divisor 0 holds", v, 0);
      arm(3, 1, 1'b1, 1'b0);
      wait_edges(40);
      rd(A_CNT, v); chk("R5 divisor 1 holds", v, 0);
      rd(A_IRQ, v); chk("R5 no pending", v, 0);

      // R8, R9 with a single-shot run: limit 2, divisor 2, 10 edges
      arm(2, 2, 1'b0, 1'b0);
      wait_edges(10);
      rd(A_IRQ, v); chk("R3 pending after wrap", v & PEND, PEND);
      chk("R9 masked irq", {31'b0, irq_o}, 0);
      wr(A_IRQ, 32'h0);
      rd(A_IRQ, v); chk("R8 write zero keeps flag", v & PEND, PEND);
      wr(A_IRQ, IE);
      chk("R9 irq asserted", {31'b0, irq_o}, 1);
      wr(A_IRQ, IE | PEND);
      rd(A_IRQ, v); chk("R8 W1C clears", v & PEND, 0);
      chk("R9 irq dropped", {31'b0, irq_o}, 0);

      // R6 single-shot stays parked; rewrite of enable does not restart
      wr(A_CTL, EN | 32'd2);
      wait_edges(20);
      rd(A_CNT, v); chk("R6 parked count", v, 0);
      rd(A_IRQ, v); chk("R6 no new wrap", v & PEND, 0);
      wr(A_CTL, 32'd2);
      wr(A_CTL, EN | 32'd2);
      wait_edges(2);
      rd(A_CNT, v); chk("R6 restart via 0-to-1", v, 1);

      // R10 freeze on disable, clear on enable
      arm(100, 2, 1'b1, 1'b0);
      wait_edges(10);
      rd(A_CNT, v); chk("R10 running", v, 5);
      wr(A_CTL, LOOP | 32'd2);
      wait_edges(20);
      rd(A_CNT, v); chk("R10 frozen", v, 5);
      wr(A_CTL, EN | LOOP | 32'd2);
      rd(A_CNT, v); chk("R10 cleared on enable", v, 0);
      wait_edges(4);
      rd(A_CNT, v); chk("R10 recount", v, 2);

      // R10 same-value rewrite keeps count and phase: N=4
      arm(100, 4, 1'b1, 1'b0);
      wait_edges(9);
      wr(A_CTL, EN | LOOP | 32'd4);
      wait_edges(10);
      rd(A_CNT, v); chk("R10 rewrite no restart", v, 5);

      // R11 divisor change restarts phase
      arm(100, 4, 1'b1, 1'b0);
      wait_edges(6);
      wr(A_CTL, EN | LOOP | 32'd5);
      rd(A_CNT, v); chk("R11 before change", v, 1);
      wait_edges(4);
      rd(A_CNT, v); chk("R11 no early tick", v, 1);
      wait_edges(1);
      rd(A_CNT, v); chk("R11 tick after new divisor", v, 2);

      // R3 R4 R7 randomized runs
      for (int i = 0; i < 40; i++) begin
         int  n   = 2 + int'($urandom % 8);
         int  lim = int'($urandom % 21);
         bit  lp  = 1'($urandom);
         bit  ie  = 1'($urandom);
         int  k   = 1 + int'($urandom % 300);
         bit  ep;
         arm(lim, n, lp, ie);
         wait_edges(k);
         ep = exp_pend(k, n, lim);
         rd(A_CNT, v);
         chk(lp ? "R7 loop count" : "R4 count", v, exp_count(k, n, lim, lp));
         rd(A_IRQ, v);
         chk("R3 pending", v & PEND, ep ? PEND : 32'h0);
         chk("R9 irq", {31'b0, irq_o}, {31'b0, ep & ie});
      end

      // R4 upper divisor: no tick before N edges
      arm(5, 65535, 1'b1, 1'b0);
      wait_edges(200);
      rd(A_CNT, v); chk("R4 large divisor", v, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule